// File: doc/BRIEF.md
# I2C Mode Register Bank

This block is the serial control port of a text display controller. It answers as a slave on a two-wire I2C bus at one fixed 7-bit address and holds eleven byte-wide mode registers, numbered 0 to 10. It also provides a data port at pointer 11. Through that port the bus master streams characters into or out of the display memory. A status byte can be read from the same pointer instead of memory data. The first byte of a write transfer loads the register pointer. Every later byte lands in the register the pointer names. The pointer then moves on only inside three fixed chains, and the last register of each chain keeps the pointer where it is.

Register 9 and register 10 together form the memory cursor. Register 9 holds the row, a bank select bit and a one-shot clear command. Register 10 holds the column. Every access to the data port moves the cursor forward, wrapping from the last column to the start of the next row. Bytes written to register 3 are passed out as page-request items. Each item carries a slot index, which starts from a field in register 2 and steps on with each byte. The open-drain SDA line is modelled as an output enable that pulls the wire low. The memory is outside the block and answers a read strobe one clock later.

Top module: `i2cModeRegs`

## Requirements
- R1: The block acknowledges only the 7-bit address 0010001. After any other address it never drives SDA, and the bytes that follow leave every register unchanged. It only changes its SDA drive while SCL is low.
- R2: After reset, registers 1, 5 and 6 hold 0x03, every other register holds 0x00, and SDA is released.
- R3: In a write transfer, the first data byte loads the pointer from its bits 3:0. Later bytes write the register named by the pointer. The pointer then steps 0→1→2→3, and register 3 is terminal, so further bytes never reach register 4.
- R4: The pointer also steps 5→6→7 and 9→10→11. Registers 7 and 11 are terminal, and registers 4 and 8 keep 0x00.
- R5: Bits with no function are stored as 0. The kept-bit masks are 0xF5 for register 0, 0xAF for register 1, 0x0F for register 2 and 0x1F for register 3.
- R6: A byte written to register 3 yields one page-request strobe carrying data bits 4:0. Its slot starts at register 2 bits 2:0 and steps by one per byte, wrapping from 6 to 0. A start value above 6 selects slot 0.
- R7: A byte written to pointer 11 yields one memory write strobe with data bits 6:0 at the current cursor. The cursor is row = register 9 bits 4:0, bank = register 9 bit 5 and column = register 10 bits 5:0. The column then advances, and after column 39 it returns to 0 and the row increases by one.
- R8: A read transfer returns bytes starting at the current pointer and follows the same chains. Registers 0 to 10 read as 0x00. When register 0 bit 0 is 0, pointer 11 returns the memory byte at the cursor and then advances the cursor.
- R9: When register 0 bit 0 is 1, pointer 11 reads the status byte {525-line flag, 5-bit ROM version (default 01000), text quality, sync quality} from bit 7 down to bit 0. The cursor does not move and no memory read is issued.
- R10: Writing register 9 with bit 6 set gives exactly one clock of clear-memory pulse, after which bit 6 reads back as 0 while the other bits keep the written value.
- R11: A byte the master does not acknowledge ends the read: no further fetch happens, so the cursor stays one place past the last byte that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls the data line low |
| regsOut | output | 88 | Registers 0 to 10, register n at bits 8n+7:8n |
| curRow | output | 5 | Cursor row |
| curCol | output | 6 | Cursor column |
| curExt | output | 1 | Cursor bank: 0 display, 1 extension |
| clearMem | output | 1 | One-clock clear-memory command |
| memWrEn | output | 1 | Memory write strobe at the cursor |
| memRdEn | output | 1 | Memory read strobe at the cursor |
| memWrData | output | 7 | Memory write data |
| memRdData | input | 7 | Memory read data, valid the clock after memRdEn |
| prWrEn | output | 1 | Page-request item strobe |
| prSlot | output | 3 | Page-request slot index |
| prData | output | 5 | Page-request item data |
| syncOk | input | 1 | Sync and PLL quality good |
| textOk | input | 1 | Text signal quality good |
| is525 | input | 1 | 525-line video detected |

## Verification
The hardest state to reach from the ports is the cursor crossing column 39 while bytes are streaming. The same difficulty applies to the read path ending on a master NACK, where exactly one fetch per sent byte must have happened. To reach these, the stimulus loads pointer 9 and writes a row and a column of 37, then streams four bytes through pointer 11. A second transfer reloads the pointer and reads across the chain into the data port, ending with a NACK, and the bench then reads the cursor back from the register outputs. The page-request slot wrap is reached in the same way, by starting register 2 at slot 5 and writing three bytes to register 3.

// File: rtl/i2cModeRegsPkg.sv
package i2cModeRegsPkg;

  localparam int REG_COUNT = 11;
  localparam int PTR_W     = 4;
  localparam int ROW_W     = 5;
  localparam int COL_W     = 6;

  localparam logic [PTR_W-1:0] PTR_ADV    = 4'd0;
  localparam logic [PTR_W-1:0] PTR_SLOT   = 4'd2;
  localparam logic [PTR_W-1:0] PTR_PAGE   = 4'd3;
  localparam logic [PTR_W-1:0] PTR_ROW    = 4'd9;
  localparam logic [PTR_W-1:0] PTR_COL    = 4'd10;
  localparam logic [PTR_W-1:0] PTR_STREAM = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WR_ACK, ST_READ, ST_RD_ACK
  } busStateT;

  typedef struct packed {
    logic       ptrLoad;
    logic       regWr;
    logic       fetch;
    logic [7:0] data;
  } ctrlStrobeT;

  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      0:               return 8'hF5;
      1:               return 8'hAF;
      2:               return 8'h0F;
      3:               return 8'h1F;
      5, 6, 7, 9, 10:  return 8'hFF;
      default:         return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] regReset(input int idx);
    case (idx)
      1, 5, 6: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic ptrSteps(input logic [PTR_W-1:0] p);
    return (p == 4'd0) || (p == 4'd1) || (p == 4'd2) || (p == 4'd5) ||
           (p == 4'd6) || (p == 4'd9) || (p == 4'd10);
  endfunction

endpackage

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cModeRegsPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0010001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output ctrlStrobeT strobe,
  output logic       sdaOe
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busStateT   state;
  logic [2:0] bitCnt;
  logic [7:0] shiftQ;
  logic       byteFull, firstQ, readQ, masterAck, sdaOeQ;
  ctrlStrobeT strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftQ    <= '0;
      byteFull  <= 1'b0;
      firstQ    <= 1'b0;
      readQ     <= 1'b0;
      masterAck <= 1'b0;
      sdaOeQ    <= 1'b0;
      strobeQ   <= '0;
    end else begin
      strobeQ <= '0;
      if (startDet) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        byteFull <= 1'b0;
        firstQ   <= 1'b1;
        sdaOeQ   <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        sdaOeQ <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (sclRise && !byteFull) begin
              shiftQ <= {shiftQ[6:0], sdaS};
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) byteFull <= 1'b1;
            end else if (sclFall && byteFull) begin
              byteFull <= 1'b0;
              if (state == ST_ADDR) begin
                if (shiftQ[7:1] == DEV_ADDR) begin
                  state  <= ST_ADDR_ACK;
                  sdaOeQ <= 1'b1;
                  readQ  <= shiftQ[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state           <= ST_WR_ACK;
                sdaOeQ          <= 1'b1;
                strobeQ.ptrLoad <= firstQ;
                strobeQ.regWr   <= !firstQ;
                strobeQ.data    <= shiftQ;
                firstQ          <= 1'b0;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclRise && readQ) begin
              strobeQ.fetch <= 1'b1;
            end else if (sclFall) begin
              bitCnt <= '0;
              if (readQ) begin
                state  <= ST_READ;
                shiftQ <= rdByte;
                sdaOeQ <= !rdByte[7];
              end else begin
                state  <= ST_WRITE;
                sdaOeQ <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (sclFall) begin
              state  <= ST_WRITE;
              sdaOeQ <= 1'b0;
            end
          end
          ST_READ: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                sdaOeQ <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                bitCnt <= bitCnt + 3'd1;
                shiftQ <= {shiftQ[6:0], 1'b0};
                sdaOeQ <= !shiftQ[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              masterAck     <= !sdaS;
              strobeQ.fetch <= !sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                state  <= ST_READ;
                shiftQ <= rdByte;
                sdaOeQ <= !rdByte[7];
                bitCnt <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign strobe = strobeQ;
  assign sdaOe  = sdaOeQ;

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cModeRegsPkg::*;
#(
  parameter int         COLS    = 40,
  parameter int         SLOTS   = 7,
  parameter logic [4:0] ROM_VER = 5'b01000,
  localparam int        SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  output logic [7:0]             rdByte,
  output logic [REG_COUNT*8-1:0] regsOut,
  output logic [ROW_W-1:0]       curRow,
  output logic [COL_W-1:0]       curCol,
  output logic                   curExt,
  output logic                   clearMem,
  output logic                   memWrEn,
  output logic                   memRdEn,
  output logic [6:0]             memWrData,
  input  logic [6:0]             memRdData,
  output logic                   prWrEn,
  output logic [SLOT_W-1:0]      prSlot,
  output logic [4:0]             prData,
  input  logic                   syncOk,
  input  logic                   textOk,
  input  logic                   is525
);

  logic [REG_COUNT-1:0][7:0] regQ;
  logic [PTR_W-1:0]          ptrQ;
  logic [SLOT_W-1:0]         slotQ;
  logic [7:0]                txQ;
  logic                      memPendQ;

  logic onStream, statusSel, access, cursorStep;
  logic [2:0] startCol;
  logic [7:0] statusByte;

  assign onStream   = (ptrQ == PTR_STREAM);
  assign statusSel  = regQ[PTR_ADV][0];
  assign access     = strobe.regWr | strobe.fetch;
  assign memWrEn    = strobe.regWr & onStream;
  assign memRdEn    = strobe.fetch & onStream & ~statusSel;
  assign cursorStep = memWrEn | memRdEn;
  assign prWrEn     = strobe.regWr & (ptrQ == PTR_PAGE);
  assign startCol   = strobe.data[2:0];
  assign statusByte = {is525, ROM_VER, textOk, syncOk};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.ptrLoad) begin
      ptrQ <= strobe.data[PTR_W-1:0];
    end else if (access && ptrSteps(ptrQ)) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regQ[i] <= regReset(i);
    end else begin
      if (regQ[PTR_ROW][6]) regQ[PTR_ROW][6] <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++) begin
        if (strobe.regWr && ptrQ == PTR_W'(i)) regQ[i] <= strobe.data & regMask(i);
      end
      if (cursorStep) begin
        if (int'(regQ[PTR_COL][COL_W-1:0]) >= COLS - 1) begin
          regQ[PTR_COL][COL_W-1:0] <= '0;
          regQ[PTR_ROW][ROW_W-1:0] <= regQ[PTR_ROW][ROW_W-1:0] + 1'b1;
        end else begin
          regQ[PTR_COL][COL_W-1:0] <= regQ[PTR_COL][COL_W-1:0] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (strobe.regWr && ptrQ == PTR_SLOT) begin
      slotQ <= (int'(startCol) < SLOTS) ? SLOT_W'(startCol) : '0;
    end else if (prWrEn) begin
      slotQ <= (int'(slotQ) == SLOTS - 1) ? '0 : slotQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ      <= '0;
      memPendQ <= 1'b0;
    end else begin
      memPendQ <= 1'b0;
      if (memPendQ) txQ <= {1'b0, memRdData};
      if (strobe.fetch) begin
        if (!onStream)      txQ      <= 8'h00;
        else if (statusSel) txQ      <= statusByte;
        else                memPendQ <= 1'b1;
      end
    end
  end

  assign rdByte    = txQ;
  assign regsOut   = regQ;
  assign curRow    = regQ[PTR_ROW][ROW_W-1:0];
  assign curExt    = regQ[PTR_ROW][5];
  assign clearMem  = regQ[PTR_ROW][6];
  assign curCol    = regQ[PTR_COL][COL_W-1:0];
  assign memWrData = strobe.data[6:0];
  assign prSlot    = slotQ;
  assign prData    = strobe.data[4:0];

endmodule

// File: rtl/i2cModeRegs.sv
module i2cModeRegs
  import i2cModeRegsPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0010001,
  parameter int         COLS     = 40,
  parameter int         SLOTS    = 7,
  parameter logic [4:0] ROM_VER  = 5'b01000,
  localparam int        SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  output logic [REG_COUNT*8-1:0] regsOut,
  output logic [ROW_W-1:0]       curRow,
  output logic [COL_W-1:0]       curCol,
  output logic                   curExt,
  output logic                   clearMem,
  output logic                   memWrEn,
  output logic                   memRdEn,
  output logic [6:0]             memWrData,
  input  logic [6:0]             memRdData,
  output logic                   prWrEn,
  output logic [SLOT_W-1:0]      prSlot,
  output logic [4:0]             prData,
  input  logic                   syncOk,
  input  logic                   textOk,
  input  logic                   is525
);

  ctrlStrobeT strobe;
  logic [7:0] rdByte;

  i2cRegCtrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(2)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rdByte (rdByte),
    .strobe (strobe),
    .sdaOe  (sdaOe)
  );

  i2cRegData #(.COLS(COLS), .SLOTS(SLOTS), .ROM_VER(ROM_VER)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdByte    (rdByte),
    .regsOut   (regsOut),
    .curRow    (curRow),
    .curCol    (curCol),
    .curExt    (curExt),
    .clearMem  (clearMem),
    .memWrEn   (memWrEn),
    .memRdEn   (memRdEn),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .prWrEn    (prWrEn),
    .prSlot    (prSlot),
    .prData    (prData),
    .syncOk    (syncOk),
    .textOk    (textOk),
    .is525     (is525)
  );

endmodule

// File: rtl/i2cModeRegsChecker.sv
module i2cModeRegsChecker #(
  parameter int COLS   = 40,
  parameter int SLOTS  = 7,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic              prWrEn,
  input logic [SLOT_W-1:0] prSlot,
  input logic [5:0]        curCol,
  input logic              clearMem,
  input logic              selStatus
);

  assert_sda_while_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn)
    else $error("SDA drive changed while SCL high");

  assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    prWrEn |-> (int'(prSlot) < SLOTS))
    else $error("page-request slot out of range");

  assert_col_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(curCol) < COLS)
    else $error("cursor column past last column");

  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, memRdEn, prWrEn}))
    else $error("more than one access strobe at once");

  assert_status_no_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !selStatus)
    else $error("memory read while status selected");

  assert_clear_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    clearMem |=> !clearMem)
    else $error("clear-memory command longer than one clock");

endmodule

bind i2cModeRegs i2cModeRegsChecker #(.COLS(COLS), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaOe     (sdaOe),
  .memWrEn   (memWrEn),
  .memRdEn   (memRdEn),
  .prWrEn    (prWrEn),
  .prSlot    (prSlot),
  .curCol    (curCol),
  .clearMem  (clearMem),
  .selStatus (regsOut[0])
);

// File: tb/test_i2cModeRegs.sv
`timescale 1ns/1ps
module test_i2cModeRegs;

  localparam int PHASE = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, sdaLine;
  logic [87:0] regsOut;
  logic [4:0] curRow;
  logic [5:0] curCol;
  logic curExt, clearMem, memWrEn, memRdEn, prWrEn;
  logic [6:0] memWrData;
  logic [6:0] memRdData = '0;
  logic [2:0] prSlot;
  logic [4:0] prData;
  logic syncOk = 1'b0, textOk = 1'b0, is525 = 1'b0;

  int total = 0, bad = 0, clearCount = 0;
  bit doneFlag = 0;

  logic [18:0] expWr[$];
  logic [7:0]  expPr[$];
  logic [7:0]  txBuf[$];
  logic [7:0]  rxBuf[8];
  bit          addrAck;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  i2cModeRegs i_i2cModeRegs (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regsOut(regsOut), .curRow(curRow), .curCol(curCol), .curExt(curExt),
    .clearMem(clearMem), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memWrData(memWrData), .memRdData(memRdData), .prWrEn(prWrEn),
    .prSlot(prSlot), .prData(prData), .syncOk(syncOk), .textOk(textOk),
    .is525(is525)
  );

  function automatic logic [6:0] memPat(input logic e, input logic [4:0] r, input logic [5:0] c);
    return 7'((int'(r) * 7 + int'(c) * 3 + (e ? 50 : 0)) % 128);
  endfunction

  function automatic logic [7:0] regAt(input int idx);
    return regsOut[8*idx +: 8];
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memPat(curExt, curRow, curCol);

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [18:0] wItem;
    logic [7:0]  pItem;
    if (rstN && memWrEn) begin
      if (expWr.size() == 0) checkEq("R7 unexpected memory write", {curExt, curRow, curCol, memWrData}, 0);
      else begin
        wItem = expWr.pop_front();
        checkEq("R7 memory write", {curExt, curRow, curCol, memWrData}, wItem);
      end
    end
    if (rstN && prWrEn) begin
      if (expPr.size() == 0) checkEq("R6 unexpected page request", {prSlot, prData}, 0);
      else begin
        pItem = expPr.pop_front();
        checkEq("R6 page request", {prSlot, prData}, pItem);
      end
    end
    if (rstN && clearMem) clearCount++;
  end

  task automatic pause();
    repeat (PHASE) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclDrv = 1'b1; pause();
    sdaDrv = 1'b0; pause();
    sclDrv = 1'b0; pause();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; pause();
    sclDrv = 1'b1; pause();
    sdaDrv = 1'b1; pause(); pause();
  endtask

  task automatic putBit(input logic b);
    sdaDrv = b; pause();
    sclDrv = 1'b1; pause();
    sclDrv = 1'b0; pause();
  endtask

  task automatic getBit(output logic b);
    sdaDrv = 1'b1; pause();
    sclDrv = 1'b1; repeat (PHASE / 2) @(negedge clk);
    b = sdaLine; repeat (PHASE / 2) @(negedge clk);
    sclDrv = 1'b0; pause();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(nack);
  endtask

  task automatic writeTxn(input logic [6:0] addr);
    bit a;
    busStart();
    sendByte({addr, 1'b0}, addrAck);
    foreach (txBuf[i]) sendByte(txBuf[i], a);
    busStop();
  endtask

  task automatic readTxn(input int n);
    bit a;
    logic [7:0] v;
    busStart();
    sendByte({7'b0010001, 1'b1}, addrAck);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, v);
      rxBuf[i] = v;
    end
    busStop();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!doneFlag) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    for (int i = 0; i < 11; i++)
      checkEq($sformatf("R2 reset reg%0d", i), regAt(i), (i == 1 || i == 5 || i == 6) ? 8'h03 : 8'h00);
    checkEq("R2 sda released", sdaOe, 0);

    // R1 foreign address is ignored
    txBuf = '{8'h01, 8'h55};
    writeTxn(7'b0100010);
    checkEq("R1 foreign address nack", addrAck, 0);
    checkEq("R1 reg1 untouched", regAt(1), 8'h03);

    // R3 R5 R6 chain 0..3, masks, page requests
    expPr.push_back({3'd5, 5'h1F});
    expPr.push_back({3'd6, 5'h03});
    expPr.push_back({3'd0, 5'h04});
    txBuf = '{8'h00, 8'hFE, 8'hFF, 8'h05, 8'hFF, 8'h03, 8'h04};
    writeTxn(7'b0010001);
    checkEq("R1 own address ack", addrAck, 1);
    checkEq("R5 reg0 mask", regAt(0), 8'hF4);
    checkEq("R5 reg1 mask", regAt(1), 8'hAF);
    checkEq("R3 reg2 via chain", regAt(2), 8'h05);
    checkEq("R3 reg3 last byte", regAt(3), 8'h04);
    checkEq("R3 reg4 not reached", regAt(4), 8'h00);

    // R4 chain 5..7
    txBuf = '{8'h05, 8'h11, 8'h22, 8'h33, 8'h44};
    writeTxn(7'b0010001);
    checkEq("R4 reg5", regAt(5), 8'h11);
    checkEq("R4 reg6", regAt(6), 8'h22);
    checkEq("R4 reg7 terminal", regAt(7), 8'h44);
    checkEq("R4 reg8 untouched", regAt(8), 8'h00);

    // R7 stream writes across column 39
    expWr.push_back({1'b0, 5'd3, 6'd37, 7'h41});
    expWr.push_back({1'b0, 5'd3, 6'd38, 7'h42});
    expWr.push_back({1'b0, 5'd3, 6'd39, 7'h43});
    expWr.push_back({1'b0, 5'd4, 6'd0,  7'h44});
    txBuf = '{8'h09, 8'h03, 8'h25, 8'hC1, 8'h42, 8'h43, 8'h44};
    writeTxn(7'b0010001);
    checkEq("R7 row after wrap", regAt(9), 8'h04);
    checkEq("R7 column after wrap", regAt(10), 8'h01);

    // R8 R11 read from pointer 9 through the stream port
    txBuf = '{8'h09};
    writeTxn(7'b0010001);
    readTxn(4);
    checkEq("R8 read reg9 as zero", rxBuf[0], 8'h00);
    checkEq("R8 read reg10 as zero", rxBuf[1], 8'h00);
    checkEq("R8 stream byte one", rxBuf[2], {1'b0, memPat(1'b0, 5'd4, 6'd1)});
    checkEq("R8 stream byte two", rxBuf[3], {1'b0, memPat(1'b0, 5'd4, 6'd2)});
    checkEq("R11 cursor after nack", regAt(10), 8'h03);

    // R9 status select
    syncOk = 1'b1; textOk = 1'b0; is525 = 1'b1;
    txBuf = '{8'h00, 8'hF5};
    writeTxn(7'b0010001);
    txBuf = '{8'h0B};
    writeTxn(7'b0010001);
    readTxn(2);
    checkEq("R9 status byte first", rxBuf[0], 8'hA1);
    checkEq("R9 status byte again", rxBuf[1], 8'hA1);
    checkEq("R9 cursor unmoved", regAt(10), 8'h03);

    // R10 clear-memory one-shot
    txBuf = '{8'h09, 8'h44};
    writeTxn(7'b0010001);
    checkEq("R10 clear bit self-resets", regAt(9), 8'h04);
    checkEq("R10 clear pulse count", clearCount, 1);

    checkEq("R7 all memory writes seen", expWr.size(), 0);
    checkEq("R6 all page requests seen", expPr.size(), 0);

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule